// File: doc/BRIEF.md
# Beverage Brewing Sequence Controller

This block sequences the preparation of one cup of coffee. After a start request it runs the grinder until enough ground coffee is on hand, then pours a fixed number of coffee doses, waits for the water to reach brewing temperature, and pours the water. It then adds either milk or the requested number of sugar doses. Finally it lights a ready lamp until the cup is taken away. Water heating begins as soon as the cycle starts, so that the water warms while the grinding and coffee pouring go on.

The controller keeps a registered state, a combinational next-state function and a combinational output decoder. Every output has an explicit value in every state. An actuator is therefore never switched off one state late, and none is left on from an earlier step. Actuator drivers, the temperature sensor and dose metering sit outside the block. Each pour output means one dose per clock cycle while it is high.

Top module: `brew_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) returns the controller to idle, and all seven outputs are low in the following cycle.
- R2: In idle, with `start_i` low, the controller stays idle with all outputs low. When `start_i` is high at an edge, `grind_o` is high in the next cycle.
- R3: `grind_o` stays high while `beans_i` is below 3. The first edge that sees `beans_i` at 3 or more moves the controller to coffee pouring.
- R4: `pour_coffee_o` is high for exactly 3 consecutive cycles per brew, and then the controller waits for temperature.
- R5: The controller waits while `temp_i` (unsigned, whole degrees) is below 90. At 90 or above, `pour_water_o` is high for exactly one cycle.
- R6: If `milk_i` is high during the water-pour cycle, `pour_milk_o` is high for one cycle and `ready_o` follows. In that brew `pour_sugar_o` never rises.
- R7: Without milk, `pour_sugar_o` pulses as many cycles as the value of `sugar_i` captured with start. The value is 3 bits, 0 to 7. A request of zero costs one cycle with no pulse before ready.
- R8: `ready_o` stays high while `cup_i` is high. After the first edge that sees `cup_i` low, the controller is idle with all outputs low.
- R9: `heat_o` is high exactly during grinding, coffee pouring and the temperature wait, and low in every other state.
- R10: At most one of `grind_o`, `pour_coffee_o`, `pour_water_o`, `pour_sugar_o`, `pour_milk_o` and `ready_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begin a brew cycle |
| beans_i | input | 4 | Doses of ground coffee available |
| temp_i | input | 8 | Water temperature, unsigned degrees |
| sugar_i | input | 3 | Requested sugar doses, captured at start |
| milk_i | input | 1 | Milk selected instead of sugar |
| cup_i | input | 1 | Cup present sensor |
| grind_o | output | 1 | Grinder on |
| pour_coffee_o | output | 1 | Pour one coffee dose |
| pour_water_o | output | 1 | Pour the hot water |
| pour_sugar_o | output | 1 | Pour one sugar dose |
| pour_milk_o | output | 1 | Pour milk |
| heat_o | output | 1 | Water heater on |
| ready_o | output | 1 | Ready lamp |

## Verification
A behavioural model in the bench steps alongside the design, and all outputs are compared on every cycle. Brews are run with:
- a short and a long shortage of ground coffee, which separates the grinder wait from the pour count;
- temperatures stepping through 89 and then 90, which exposes an off-by-one in the threshold;
- sugar requests of 0, 2 and 7 and a milk brew with sugar requested, which separate the zero-dose path, the dose count at its limit and the branch priority;
- a reset in the middle of a brew, which confirms that no actuator stays on.

// File: rtl/brew_ctrl.sv
module brew_ctrl #(
  parameter int BEAN_W       = 4,
  parameter int TEMP_W       = 8,
  parameter int SUGAR_W      = 3,
  parameter int COFFEE_DOSES = 3,
  parameter int HOT_DEG      = 90
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [BEAN_W-1:0]  beans_i,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic [SUGAR_W-1:0] sugar_i,
  input  logic               milk_i,
  input  logic               cup_i,
  output logic               grind_o,
  output logic               pour_coffee_o,
  output logic               pour_water_o,
  output logic               pour_sugar_o,
  output logic               pour_milk_o,
  output logic               heat_o,
  output logic               ready_o
);

  localparam int CW = $clog2(COFFEE_DOSES + 1);
  localparam logic [CW-1:0]     C_LAST  = CW'(COFFEE_DOSES - 1);
  localparam logic [BEAN_W-1:0] B_NEED  = BEAN_W'(COFFEE_DOSES);
  localparam logic [TEMP_W-1:0] T_HOT   = TEMP_W'(HOT_DEG);

  typedef enum logic [2:0] {
    S_IDLE, S_GRIND, S_COFFEE, S_HEATWAIT, S_WATER, S_SUGAR, S_MILK, S_READY
  } st_t;

  st_t                state, nxt;
  logic [CW-1:0]      cof_cnt;
  logic [SUGAR_W-1:0] sug_cnt, sug_req;

  wire enough_beans = beans_i >= B_NEED;
  wire water_hot    = temp_i >= T_HOT;
  wire sugar_done   = sug_cnt == sug_req;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nxt;
  end

  always_ff @(posedge clk) begin
    if (rst || state == S_IDLE) begin
      cof_cnt <= '0;
      sug_cnt <= '0;
    end else begin
      if (state == S_COFFEE)                cof_cnt <= cof_cnt + 1'b1;
      if (state == S_SUGAR && !sugar_done)  sug_cnt <= sug_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         sug_req <= '0;
    else if (state == S_IDLE && start_i) sug_req <= sugar_i;
  end

  always_comb begin
    unique case (state)
      S_IDLE:     nxt = start_i ? S_GRIND : S_IDLE;
      S_GRIND:    nxt = enough_beans ? S_COFFEE : S_GRIND;
      S_COFFEE:   nxt = (cof_cnt == C_LAST) ? S_HEATWAIT : S_COFFEE;
      S_HEATWAIT: nxt = water_hot ? S_WATER : S_HEATWAIT;
      S_WATER:    nxt = milk_i ? S_MILK : S_SUGAR;
      S_SUGAR:    nxt = sugar_done ? S_READY : S_SUGAR;
      S_MILK:     nxt = S_READY;
      S_READY:    nxt = cup_i ? S_READY : S_IDLE;
    endcase
  end

  always_comb begin
    unique case (state)
      S_IDLE: begin
        grind_o = 1'b0; pour_coffee_o = 1'b0; pour_water_o = 1'b0;
        pour_sugar_o = 1'b0; pour_milk_o = 1'b0; heat_o = 1'b0; ready_o = 1'b0;
      end
      S_GRIND: begin
        grind_o = 1'b1; pour_coffee_o = 1'b0; pour_water_o = 1'b0;
        pour_sugar_o = 1'b0; pour_milk_o = 1'b0; heat_o = 1'b1; ready_o = 1'b0;
      end
      S_COFFEE: begin
        grind_o = 1'b0; pour_coffee_o = 1'b1; pour_water_o = 1'b0;
        pour_sugar_o = 1'b0; pour_milk_o = 1'b0; heat_o = 1'b1; ready_o = 1'b0;
      end
      S_HEATWAIT: begin
        grind_o = 1'b0; pour_coffee_o = 1'b0; pour_water_o = 1'b0;
        pour_sugar_o = 1'b0; pour_milk_o = 1'b0; heat_o = 1'b1; ready_o = 1'b0;
      end
      S_WATER: begin
        grind_o = 1'b0; pour_coffee_o = 1'b0; pour_water_o = 1'b1;
        pour_sugar_o = 1'b0; pour_milk_o = 1'b0; heat_o = 1'b0; ready_o = 1'b0;
      end
      S_SUGAR: begin
        grind_o = 1'b0; pour_coffee_o = 1'b0; pour_water_o = 1'b0;
        pour_sugar_o = !sugar_done; pour_milk_o = 1'b0; heat_o = 1'b0; ready_o = 1'b0;
      end
      S_MILK: begin
        grind_o = 1'b0; pour_coffee_o = 1'b0; pour_water_o = 1'b0;
        pour_sugar_o = 1'b0; pour_milk_o = 1'b1; heat_o = 1'b0; ready_o = 1'b0;
      end
      S_READY: begin
        grind_o = 1'b0; pour_coffee_o = 1'b0; pour_water_o = 1'b0;
        pour_sugar_o = 1'b0; pour_milk_o = 1'b0; heat_o = 1'b0; ready_o = 1'b1;
      end
    endcase
  end

  a_r1_reset_quiet: assert property (@(posedge clk) $past(rst) |->
    !(grind_o || pour_coffee_o || pour_water_o || pour_sugar_o || pour_milk_o || heat_o || ready_o));
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && !start_i) |=> state == S_IDLE);
  a_r2_start_grind: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && start_i) |=> grind_o);
  a_r3_grind_wait: assert property (@(posedge clk) disable iff (rst)
    (grind_o && !enough_beans) |=> grind_o);
  a_r4_coffee_end: assert property (@(posedge clk) disable iff (rst)
    (pour_coffee_o && cof_cnt == C_LAST) |=> (heat_o && !pour_coffee_o));
  a_r5_water_single: assert property (@(posedge clk) disable iff (rst)
    pour_water_o |=> !pour_water_o);
  a_r6_milk_to_ready: assert property (@(posedge clk) disable iff (rst)
    pour_milk_o |=> ready_o);
  a_r7_sugar_limit: assert property (@(posedge clk) disable iff (rst)
    (state == S_SUGAR && sugar_done) |=> ready_o);
  a_r8_ready_hold: assert property (@(posedge clk) disable iff (rst)
    (ready_o && cup_i) |=> ready_o);
  a_r9_heat_cover: assert property (@(posedge clk) disable iff (rst)
    (grind_o || pour_coffee_o) |-> heat_o);
  a_r10_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grind_o, pour_coffee_o, pour_water_o, pour_sugar_o, pour_milk_o, ready_o}));

endmodule

// File: tb/test_brew_ctrl.sv
`timescale 1ns/1ps
module test_brew_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 0, milk_i = 0, cup_i = 0;
  logic [3:0] beans_i = 0;
  logic [7:0] temp_i = 0;
  logic [2:0] sugar_i = 0;
  logic grind_o, pour_coffee_o, pour_water_o, pour_sugar_o, pour_milk_o, heat_o, ready_o;

  int checks = 0, fails = 0;
  int n_cof, n_wat, n_sug, n_milk;
  int m_ph = 0, m_cc = 0, m_sc = 0, m_req = 0;

  always #2.5 clk = ~clk;

  brew_ctrl i_brew_ctrl (.clk(clk), .rst(rst), .start_i(start_i), .beans_i(beans_i),
    .temp_i(temp_i), .sugar_i(sugar_i), .milk_i(milk_i), .cup_i(cup_i),
    .grind_o(grind_o), .pour_coffee_o(pour_coffee_o), .pour_water_o(pour_water_o),
    .pour_sugar_o(pour_sugar_o), .pour_milk_o(pour_milk_o), .heat_o(heat_o), .ready_o(ready_o));

  // behavioural reference: phases 0 idle 1 grind 2 coffee 3 wait 4 water 5 sugar 6 milk 7 ready
  always @(posedge clk) begin
    if (rst) begin m_ph = 0; m_cc = 0; m_sc = 0; end
    else case (m_ph)
      0: begin m_cc = 0; m_sc = 0; if (start_i) begin m_req = sugar_i; m_ph = 1; end end
      1: if (beans_i >= 3) m_ph = 2;
      2: begin m_cc++; if (m_cc == 3) m_ph = 3; end
      3: if (temp_i >= 90) m_ph = 4;
      4: m_ph = milk_i ? 6 : 5;
      5: if (m_sc == m_req) m_ph = 7; else m_sc++;
      6: m_ph = 7;
      default: if (!cup_i) m_ph = 0;
    endcase
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(grind_o == (m_ph == 1), "R3 grind", grind_o, m_ph == 1);
    chk(pour_coffee_o == (m_ph == 2), "R4 coffee", pour_coffee_o, m_ph == 2);
    chk(pour_water_o == (m_ph == 4), "R5 water", pour_water_o, m_ph == 4);
    chk(pour_sugar_o == (m_ph == 5 && m_sc < m_req), "R7 sugar", pour_sugar_o, m_ph == 5 && m_sc < m_req);
    chk(pour_milk_o == (m_ph == 6), "R6 milk", pour_milk_o, m_ph == 6);
    chk(ready_o == (m_ph == 7), "R8 ready", ready_o, m_ph == 7);
    chk(heat_o == (m_ph >= 1 && m_ph <= 3), "R9 heat", heat_o, m_ph >= 1 && m_ph <= 3);
    chk($countones({grind_o, pour_coffee_o, pour_water_o, pour_sugar_o, pour_milk_o, ready_o}) <= 1,
        "R10 exclusive", $countones({grind_o, pour_coffee_o, pour_water_o, pour_sugar_o, pour_milk_o, ready_o}), 1);
    n_cof += pour_coffee_o; n_wat += pour_water_o; n_sug += pour_sugar_o; n_milk += pour_milk_o;
  endtask

  function automatic int outs();
    return {grind_o, pour_coffee_o, pour_water_o, pour_sugar_o, pour_milk_o, heat_o, ready_o};
  endfunction

  task automatic brew(input int sug, input bit milk, input int short_cyc, input int cup_cyc);
    n_cof = 0; n_wat = 0; n_sug = 0; n_milk = 0;
    beans_i = 1; temp_i = 70; cup_i = 1; milk_i = milk; sugar_i = 3'(sug);
    start_i = 1; step(); start_i = 0;
    chk(grind_o == 1, "R2 start to grind", grind_o, 1);
    sugar_i = 3'(7 - sug);
    for (int i = 0; i < short_cyc; i++) step();
    chk(grind_o == 1, "R3 grinder held while short", grind_o, 1);
    beans_i = 3;
    for (int i = 0; i < 5; i++) step();
    temp_i = 89;
    for (int i = 0; i < 3; i++) step();
    chk(pour_water_o == 0 && heat_o == 1, "R5 below 90 waits", pour_water_o, 0);
    temp_i = 90;
    for (int i = 0; i < 20 && !ready_o; i++) step();
    chk(ready_o == 1, "R8 reached ready", ready_o, 1);
    for (int i = 0; i < cup_cyc; i++) step();
    chk(ready_o == 1, "R8 ready while cup", ready_o, 1);
    cup_i = 0; step();
    chk(outs() == 0, "R8 idle after cup taken", outs(), 0);
    chk(n_cof == 3, "R4 coffee doses", n_cof, 3);
    chk(n_wat == 1, "R5 water pulses", n_wat, 1);
    chk(n_sug == (milk ? 0 : sug), "R7 sugar doses", n_sug, milk ? 0 : sug);
    chk(n_milk == (milk ? 1 : 0), "R6 milk pulses", n_milk, milk ? 1 : 0);
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    step(); step(); rst = 0;
    chk(outs() == 0, "R1 reset state", outs(), 0);
    for (int i = 0; i < 4; i++) step();
    chk(outs() == 0, "R2 idle without start", outs(), 0);
    brew(2, 0, 1, 3);
    brew(0, 0, 6, 1);
    brew(3, 1, 2, 2);
    brew(7, 0, 0, 0);
    beans_i = 5; temp_i = 95; cup_i = 1; start_i = 1; step(); start_i = 0;
    step(); step();
    chk(pour_coffee_o == 1, "R4 mid brew", pour_coffee_o, 1);
    rst = 1; step(); rst = 0;
    chk(outs() == 0, "R1 reset mid brew", outs(), 0);
    step();
    chk(outs() == 0, "R1 stays idle", outs(), 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule